// File: doc/BRIEF.md
# Serial Programming Command Controller for On-Chip Flash

This block is the serial programming port of an on-chip non-volatile byte store. An external programmer drives a SPI slave link in mode 0. Each transaction starts when chip select goes low, and its first byte is an 8-bit opcode. The opcode can do one of the following:

- set or clear a write-enable latch;
- read or write a small status register;
- stream bytes out of the array from a two-byte start address;
- program bytes into the array from a two-byte start address.

The memory is a behavioural byte-wide model. It resets to all ones. Programming can only clear bits: the new value is the stored value ANDed with the incoming byte.

The port works only while the programming-enable input is high, and only after a parameterised power-up wait has elapsed. When a program transaction ends, a timed busy period follows. During that period the status register shows a ready-low flag. Commands that would alter the array or the latch are refused until the flag drops, and then the write-enable latch clears by itself. A separate MCU-side input is the only way to change the debug bit of the status register.

Top module: `spi_flash_prog_ctrl`

## Requirements
- R1: After reset, a status read returns 0x00, every array byte reads 0xFF, and MISO is low while no transaction is selected.
- R2: Opcode 0x06 sets the write-enable latch. Opcode 0x04 clears it. Neither opcode takes further bytes.
- R3: Opcode 0x05 returns the status byte on every following byte slot. The layout is bit 7 debug, bit 6 always 0, bit 5 write-enable, bit 4 ready-low busy, bits 3:0 configuration.
- R4: Opcode 0x01 followed by one byte loads bits 3:0 and bit 5 from that byte. Bits 7, 6 and 4 are unaffected.
- R5: The debug bit changes only through the MCU port (mcu_dbg_wr_i with mcu_dbg_val_i). A status write over SPI never changes it.
- R6: Opcode 0x03 takes the address high byte, then the address low byte. It then streams bytes from consecutive addresses. The address is taken modulo MEM_DEPTH.
- R7: Opcode 0x02 takes a two-byte address, then data bytes. Each data byte is ANDed into consecutive addresses. The command acts only when write-enable is set and the block is not busy. Only the first MAX_PROG_BYTES data bytes are stored.
- R8: When chip select rises after a program command that stored at least one byte, the busy bit is high for BUSY_CYCLES clocks. It then falls, and write-enable clears in the same cycle. While busy, opcodes 0x02, 0x01 and 0x04 have no effect.
- R9: A transaction is accepted only if chip select falls while prog_i is high and PWRUP_CYCLES clocks have passed since prog_i rose. Dropping prog_i ends any transaction.
- R10: An unknown opcode makes the rest of the transaction be ignored. Raising chip select at any point returns the controller to the opcode phase.
- R11: The SPI link runs in mode 0, MSB first. Input is sampled on the rising SCK edge, and output changes on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_i | input | 1 | Programming-port enable |
| sck_i | input | 1 | SPI serial clock |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data in |
| miso_o | output | 1 | SPI data out |
| mcu_dbg_wr_i | input | 1 | MCU strobe that writes the debug bit |
| mcu_dbg_val_i | input | 1 | Value written to the debug bit |

## Verification
The main command path is driven from a table of transactions. The table mixes latch set and clear, status reads and writes, and programming with the latch both clear and set. A value is programmed over an already-programmed byte, which separates AND behaviour from plain overwrite. A read beyond the array depth separates address wrapping from a fresh location. Directed sequences then tell apart:
- a refused command from an accepted one, during the power-up wait, with the port disabled, and during the busy window;
- storage of the first allowed bytes of a burst from the dropped byte that follows them;
- an early chip-select release from a completed program command;
- a debug bit changed from the MCU side from one that an SPI status write tried to change.

// File: rtl/spf_pkg.sv
package spf_pkg;

    typedef enum logic [7:0] {
        OP_WRSR  = 8'h01,
        OP_PROG  = 8'h02,
        OP_READ  = 8'h03,
        OP_WRDIS = 8'h04,
        OP_RDSR  = 8'h05,
        OP_WREN  = 8'h06
    } spf_op_e;

    typedef enum logic [2:0] {
        S_OPC,
        S_AHI,
        S_ALO,
        S_RDAT,
        S_WDAT,
        S_SRRD,
        S_SRWR,
        S_SKIP
    } spf_state_e;

    localparam int SR_DBG  = 7;
    localparam int SR_WEN  = 5;
    localparam int SR_RDYN = 4;

endpackage

// File: rtl/spf_spi_link.sv
module spf_spi_link #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       csn_i,
    input  logic       mosi_i,
    input  logic       sel_i,
    input  logic [7:0] tx_byte_i,
    output logic       csn_s_o,
    output logic       byte_valid_o,
    output logic [7:0] rx_byte_o,
    output logic       miso_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sck_sy;
        logic [SYNC_STAGES-1:0] csn_sy;
        logic [SYNC_STAGES-1:0] mosi_sy;
        logic                   sck_prev;
        logic [7:0]             rx;
        logic [2:0]             cnt;
        logic [7:0]             tx_sh;
        logic                   valid;
    } link_t;

    link_t l_d, l_q;

    logic sck_s, mosi_s, sck_rise, sck_fall;

    assign sck_s    = l_q.sck_sy[SYNC_STAGES-1];
    assign mosi_s   = l_q.mosi_sy[SYNC_STAGES-1];
    assign sck_rise = sck_s && !l_q.sck_prev;
    assign sck_fall = !sck_s && l_q.sck_prev;

    always_comb begin
        l_d          = l_q;
        l_d.sck_sy   = {l_q.sck_sy[SYNC_STAGES-2:0], sck_i};
        l_d.csn_sy   = {l_q.csn_sy[SYNC_STAGES-2:0], csn_i};
        l_d.mosi_sy  = {l_q.mosi_sy[SYNC_STAGES-2:0], mosi_i};
        l_d.sck_prev = sck_s;
        l_d.valid    = 1'b0;
        if (!sel_i) begin
            l_d.cnt   = 3'd0;
            l_d.tx_sh = 8'h00;
        end else if (sck_rise) begin
            l_d.rx  = {l_q.rx[6:0], mosi_s};
            l_d.cnt = l_q.cnt + 3'd1;
            if (l_q.cnt == 3'd7) begin
                l_d.valid = 1'b1;
            end
        end else if (sck_fall) begin
            if (l_q.cnt == 3'd0) begin
                l_d.tx_sh = tx_byte_i;
            end else begin
                l_d.tx_sh = {l_q.tx_sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q        <= '0;
            l_q.csn_sy <= '1;
        end else begin
            l_q <= l_d;
        end
    end

    assign csn_s_o      = l_q.csn_sy[SYNC_STAGES-1];
    assign byte_valid_o = l_q.valid;
    assign rx_byte_o    = l_q.rx;
    assign miso_o       = l_q.tx_sh[7];

    p_byte_only_selected_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(sel_i));

endmodule

// File: rtl/spf_mem.sv
module spf_mem #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= mem_q[waddr_i] & wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    p_program_clears_only_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((mem_q[$past(waddr_i)] & ~$past(mem_q[waddr_i])) == 8'h00));

endmodule

// File: rtl/spf_cmd_ctrl.sv
module spf_cmd_ctrl
    import spf_pkg::*;
#(
    parameter int MEM_DEPTH      = 256,
    parameter int PWRUP_CYCLES   = 75000,
    parameter int BUSY_CYCLES    = 2000,
    parameter int MAX_PROG_BYTES = 18432,
    localparam int AW            = $clog2(MEM_DEPTH),
    localparam int PW            = $clog2(PWRUP_CYCLES + 1),
    localparam int BW            = $clog2(BUSY_CYCLES + 1),
    localparam int NW            = $clog2(MAX_PROG_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_i,
    input  logic          csn_s_i,
    input  logic          byte_valid_i,
    input  logic [7:0]    rx_byte_i,
    input  logic [7:0]    mem_rdata_i,
    input  logic          mcu_dbg_wr_i,
    input  logic          mcu_dbg_val_i,
    output logic          sel_o,
    output logic [7:0]    tx_byte_o,
    output logic [AW-1:0] mem_raddr_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_waddr_o,
    output logic [7:0]    mem_wdata_o
);

    localparam logic [PW-1:0] PWR_DONE  = PW'(PWRUP_CYCLES);
    localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES - 1);
    localparam logic [NW-1:0] NMAX      = NW'(MAX_PROG_BYTES);

    typedef struct packed {
        spf_state_e    state;
        logic [15:0]   addr;
        logic          is_rd;
        logic [NW-1:0] nbytes;
        logic          wrote;
        logic          wen;
        logic          rdyn;
        logic          dbg;
        logic [3:0]    cfg;
        logic [BW-1:0] busy;
        logic [PW-1:0] pwr;
        logic [7:0]    tx;
        logic          fetch;
        logic          sel;
        logic          csn_prev;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic       active, csn_fell, csn_rose;
    logic [7:0] status;

    assign active   = prog_i && (c_q.pwr == PWR_DONE);
    assign csn_fell = c_q.csn_prev && !csn_s_i;
    assign csn_rose = !c_q.csn_prev && csn_s_i;
    assign status   = {c_q.dbg, 1'b0, c_q.wen, c_q.rdyn, c_q.cfg};

    always_comb begin
        c_d          = c_q;
        mem_we_o     = 1'b0;
        mem_waddr_o  = c_q.addr[AW-1:0];
        mem_wdata_o  = rx_byte_i;
        c_d.csn_prev = csn_s_i;

        // power-up wait
        if (!prog_i) begin
            c_d.pwr = '0;
        end else if (c_q.pwr != PWR_DONE) begin
            c_d.pwr = c_q.pwr + 1'b1;
        end

        // timed busy window
        if (c_q.rdyn) begin
            if (c_q.busy == '0) begin
                c_d.rdyn = 1'b0;
                c_d.wen  = 1'b0;
            end else begin
                c_d.busy = c_q.busy - 1'b1;
            end
        end

        // deferred array fetch for read streaming
        if (c_q.fetch) begin
            c_d.tx    = mem_rdata_i;
            c_d.fetch = 1'b0;
        end

        if (mcu_dbg_wr_i) begin
            c_d.dbg = mcu_dbg_val_i;
        end

        if (c_q.sel) begin
            if (csn_rose || !active) begin
                c_d.sel   = 1'b0;
                c_d.state = S_OPC;
                c_d.wrote = 1'b0;
                if (c_q.state == S_WDAT && c_q.wrote) begin
                    c_d.rdyn = 1'b1;
                    c_d.busy = BUSY_LOAD;
                end
            end else if (byte_valid_i) begin
                unique case (c_q.state)
                    S_OPC: begin
                        c_d.state = S_SKIP;
                        case (rx_byte_i)
                            OP_WREN:  c_d.wen = 1'b1;
                            OP_WRDIS: if (!c_q.rdyn) c_d.wen = 1'b0;
                            OP_RDSR: begin
                                c_d.tx    = status;
                                c_d.state = S_SRRD;
                            end
                            OP_WRSR:  if (!c_q.rdyn) c_d.state = S_SRWR;
                            OP_READ: begin
                                c_d.is_rd = 1'b1;
                                c_d.state = S_AHI;
                            end
                            OP_PROG: begin
                                if (c_q.wen && !c_q.rdyn) begin
                                    c_d.is_rd = 1'b0;
                                    c_d.state = S_AHI;
                                end
                            end
                            default: c_d.state = S_SKIP;
                        endcase
                    end
                    S_SRRD: c_d.tx = status;
                    S_SRWR: begin
                        c_d.cfg   = rx_byte_i[3:0];
                        c_d.wen   = rx_byte_i[SR_WEN];
                        c_d.state = S_SKIP;
                    end
                    S_AHI: begin
                        c_d.addr[15:8] = rx_byte_i;
                        c_d.state      = S_ALO;
                    end
                    S_ALO: begin
                        c_d.addr[7:0] = rx_byte_i;
                        c_d.nbytes    = '0;
                        if (c_q.is_rd) begin
                            c_d.fetch = 1'b1;
                            c_d.state = S_RDAT;
                        end else begin
                            c_d.state = S_WDAT;
                        end
                    end
                    S_RDAT: begin
                        c_d.addr  = c_q.addr + 16'd1;
                        c_d.fetch = 1'b1;
                    end
                    S_WDAT: begin
                        if (c_q.nbytes < NMAX) begin
                            mem_we_o   = 1'b1;
                            c_d.addr   = c_q.addr + 16'd1;
                            c_d.nbytes = c_q.nbytes + 1'b1;
                            c_d.wrote  = 1'b1;
                        end
                    end
                    S_SKIP: c_d.state = S_SKIP;
                    default: c_d.state = S_SKIP;
                endcase
            end
        end else if (csn_fell && active) begin
            c_d.sel   = 1'b1;
            c_d.state = S_OPC;
            c_d.wrote = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q          <= '0;
            c_q.state    <= S_OPC;
            c_q.csn_prev <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign sel_o       = c_q.sel;
    assign tx_byte_o   = c_q.tx;
    assign mem_raddr_o = c_q.addr[AW-1:0];

    p_wen_kept_while_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.wen) |-> !c_q.rdyn);

    p_busy_starts_after_prog_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.rdyn) |-> $past(c_q.state == S_WDAT && c_q.wrote));

    p_dbg_set_by_mcu_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.dbg) |-> $past(mcu_dbg_wr_i && mcu_dbg_val_i));

    p_write_needs_wen_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (c_q.wen && !c_q.rdyn && c_q.sel));

    p_drop_on_prog_low_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.sel && !prog_i) |=> !c_q.sel);

endmodule

// File: rtl/spi_flash_prog_ctrl.sv
module spi_flash_prog_ctrl #(
    parameter int MEM_DEPTH      = 256,
    parameter int PWRUP_CYCLES   = 75000,
    parameter int BUSY_CYCLES    = 2000,
    parameter int MAX_PROG_BYTES = 18432,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_i,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic miso_o,
    input  logic mcu_dbg_wr_i,
    input  logic mcu_dbg_val_i
);

    localparam int AW = $clog2(MEM_DEPTH);

    logic          csn_s, byte_valid, sel, mem_we;
    logic [7:0]    rx_byte, tx_byte, mem_rdata, mem_wdata;
    logic [AW-1:0] mem_raddr, mem_waddr;

    spf_spi_link #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_i        (sck_i),
        .csn_i        (csn_i),
        .mosi_i       (mosi_i),
        .sel_i        (sel),
        .tx_byte_i    (tx_byte),
        .csn_s_o      (csn_s),
        .byte_valid_o (byte_valid),
        .rx_byte_o    (rx_byte),
        .miso_o       (miso_o)
    );

    spf_cmd_ctrl #(
        .MEM_DEPTH      (MEM_DEPTH),
        .PWRUP_CYCLES   (PWRUP_CYCLES),
        .BUSY_CYCLES    (BUSY_CYCLES),
        .MAX_PROG_BYTES (MAX_PROG_BYTES)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .prog_i        (prog_i),
        .csn_s_i       (csn_s),
        .byte_valid_i  (byte_valid),
        .rx_byte_i     (rx_byte),
        .mem_rdata_i   (mem_rdata),
        .mcu_dbg_wr_i  (mcu_dbg_wr_i),
        .mcu_dbg_val_i (mcu_dbg_val_i),
        .sel_o         (sel),
        .tx_byte_o     (tx_byte),
        .mem_raddr_o   (mem_raddr),
        .mem_we_o      (mem_we),
        .mem_waddr_o   (mem_waddr),
        .mem_wdata_o   (mem_wdata)
    );

    spf_mem #(
        .DEPTH (MEM_DEPTH)
    ) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

endmodule

// File: tb/test_spi_flash_prog_ctrl.sv
module test_spi_flash_prog_ctrl;

    localparam int HALF = 8;
    localparam int BUSY = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog = 1'b0;
    logic sck = 1'b0;
    logic csn = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic dbg_wr = 1'b0;
    logic dbg_val = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] rbuf [8];

    always #10 clk = ~clk;

    spi_flash_prog_ctrl #(
        .MEM_DEPTH      (64),
        .PWRUP_CYCLES   (20),
        .BUSY_CYCLES    (BUSY),
        .MAX_PROG_BYTES (4)
    ) i_spi_flash_prog_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .prog_i        (prog),
        .sck_i         (sck),
        .csn_i         (csn),
        .mosi_i        (mosi),
        .miso_o        (miso),
        .mcu_dbg_wr_i  (dbg_wr),
        .mcu_dbg_val_i (dbg_val)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] addr;
        logic [7:0]  dat;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{8'h05, 16'h0000, 8'h00, 8'h00},  // R1 reset status
        '{8'h06, 16'h0000, 8'h00, 8'h00},
        '{8'h05, 16'h0000, 8'h00, 8'h20},  // R2 latch set
        '{8'h04, 16'h0000, 8'h00, 8'h00},
        '{8'h05, 16'h0000, 8'h00, 8'h00},  // R2 latch clear
        '{8'h02, 16'h0010, 8'h5A, 8'h00},  // R7 refused, latch clear
        '{8'h03, 16'h0010, 8'h00, 8'hFF},  // R1 erased / R7
        '{8'h06, 16'h0000, 8'h00, 8'h00},
        '{8'h02, 16'h0010, 8'h5A, 8'h00},
        '{8'h05, 16'h0000, 8'h00, 8'h00},  // R8 latch auto-clear
        '{8'h03, 16'h0010, 8'h00, 8'h5A},  // R6 read back
        '{8'h06, 16'h0000, 8'h00, 8'h00},
        '{8'h02, 16'h0010, 8'hF0, 8'h00},
        '{8'h03, 16'h0010, 8'h00, 8'h50},  // R7 AND behaviour
        '{8'h01, 16'h0000, 8'hFF, 8'h00},
        '{8'h05, 16'h0000, 8'h00, 8'h2F},  // R4 R3 layout
        '{8'h01, 16'h0000, 8'h00, 8'h00},
        '{8'h05, 16'h0000, 8'h00, 8'h00},  // R4
        '{8'h03, 16'h0050, 8'h00, 8'h50}   // R6 wrap
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        csn = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_high();
        tick(HALF);
        csn = 1'b1;
        tick(HALF);
    endtask

    // mode 0, MSB first (R11)
    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_low();
        xfer(op, d);
        cs_high();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_low();
        xfer(8'h05, d);
        xfer(8'h00, s);
        cs_high();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_low();
        xfer(8'h01, d);
        xfer(v, d);
        cs_high();
    endtask

    task automatic prog_seq(input logic [15:0] a, input int n, input logic [7:0] first);
        logic [7:0] d;
        cs_low();
        xfer(8'h02, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) begin
            xfer(first + 8'(i), d);
        end
        cs_high();
    endtask

    task automatic rd_seq(input logic [15:0] a, input int n);
        logic [7:0] d;
        cs_low();
        xfer(8'h03, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, rbuf[i]);
        end
        cs_high();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] s;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        check("R1 miso idle", {7'd0, miso}, 8'h00);

        // R9: a transaction begun during the power-up wait is refused
        prog = 1'b1;
        tick(2);
        cmd1(8'h06);
        tick(30);
        rdsr(s);
        check("R9 powerup refusal", s, 8'h00);

        for (int v = 0; v < NV; v++) begin
            unique case (VECS[v].op)
                8'h06, 8'h04: cmd1(VECS[v].op);
                8'h01: wrsr(VECS[v].dat);
                8'h05: begin
                    rdsr(s);
                    check("R3 vector status", s, VECS[v].exp);
                end
                8'h02: begin
                    prog_seq(VECS[v].addr, 1, VECS[v].dat);
                    tick(BUSY + 100);
                end
                8'h03: begin
                    rd_seq(VECS[v].addr, 1);
                    check("R6 vector read", rbuf[0], VECS[v].exp);
                end
                default: ;
            endcase
        end

        // R8: busy window
        cmd1(8'h06);
        prog_seq(16'h0020, 2, 8'h12);
        rdsr(s);
        check("R8 busy status", s, 8'h30);
        cmd1(8'h04);
        wrsr(8'h00);
        prog_seq(16'h0020, 1, 8'h00);
        rdsr(s);
        check("R8 ignored while busy", s, 8'h30);
        tick(BUSY + 200);
        rdsr(s);
        check("R8 busy end clears latch", s, 8'h00);
        rd_seq(16'h0020, 2);
        check("R8 busy program ignored", rbuf[0], 8'h12);
        check("R6 stream second", rbuf[1], 8'h13);

        // R7: byte limit
        cmd1(8'h06);
        prog_seq(16'h0030, 5, 8'h01);
        tick(BUSY + 200);
        rd_seq(16'h0030, 5);
        check("R7 limit byte 0", rbuf[0], 8'h01);
        check("R7 limit byte 3", rbuf[3], 8'h04);
        check("R7 limit drop", rbuf[4], 8'hFF);

        // R10: early release returns to opcode phase, no busy
        begin
            logic [7:0] d;
            cmd1(8'h06);
            cs_low();
            xfer(8'h02, d);
            xfer(8'h00, d);
            cs_high();
            rdsr(s);
            check("R10 abort no busy", s, 8'h20);
            cmd1(8'h04);
            // R10: unknown opcode swallows later bytes
            cs_low();
            xfer(8'hAB, d);
            xfer(8'h06, d);
            cs_high();
            rdsr(s);
            check("R10 unknown opcode", s, 8'h00);
        end

        // R5: debug bit from MCU side only
        dbg_wr = 1'b1;
        dbg_val = 1'b1;
        tick(1);
        dbg_wr = 1'b0;
        rdsr(s);
        check("R5 mcu set", s, 8'h80);
        wrsr(8'h00);
        rdsr(s);
        check("R5 spi keeps dbg", s, 8'h80);
        dbg_wr = 1'b1;
        dbg_val = 1'b0;
        tick(1);
        dbg_wr = 1'b0;
        wrsr(8'h80);
        rdsr(s);
        check("R5 spi cannot set", s, 8'h00);

        // R9: port disabled while prog low
        cmd1(8'h06);
        prog = 1'b0;
        tick(4);
        rdsr(s);
        check("R9 disabled port", s, 8'h00);
        cmd1(8'h04);
        prog = 1'b1;
        tick(30);
        rdsr(s);
        check("R9 latch kept", s, 8'h20);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule